// File: doc/BRIEF.md
# Store Coalescing Write Buffer

This block sits between a processor's store port and a slower memory bus. Each store names a 16-byte line and carries up to 16 data bytes with one enable per byte lane, so a single store can be a byte, a halfword, a word or a burst of up to 16 bytes. Stores that qualify for buffering go into a queue of line-sized entries. The queue drains to a bus master port that uses a valid/ready handshake. The processor can move on as soon as its store has been queued, and it does not wait for the bus.

Three conditions must all hold for a store to be buffered: software has switched buffering on, address translation is active, and the store's page attribute marks it bufferable. Any store that fails one of these is unbuffered. An unbuffered store waits until every older entry has left, and then passes straight to the bus port. An optional merge mode folds a store into the youngest queued entry when both use the same line. A flush request holds the drain-complete output low and refuses new stores until the queue is empty.

Top module: `store_merge_buffer`

## Requirements
- R1: After reset the queue is empty: busValid is low, flushDone is high, and stReady is high for a buffered store.
- R2: A store is queued only when cfgEnable, mmuOn and stBufferable are all 1. In that case the bus stays idle in the cycle of acceptance, and the entry appears on the bus in the next cycle.
- R3: An unbuffered store with an empty queue is shown on the bus in the same cycle (busValid high, same line, data and byte enables). stReady then follows busReady, and nothing is queued.
- R4: While any entry is pending, an unbuffered store is held off (stReady low) and the bus shows the oldest entry instead.
- R5: Entries leave in arrival order. Each carries its line address, its 128-bit data with byte lane b on bits [8b+7:8b], and one enable bit per lane.
- R6: The queue holds 8 entries. When it is full, stReady is low for a buffered store that does not merge.
- R7: With cfgMerge at 1 and at least two entries queued, a buffered store to the same line as the youngest entry updates that entry's enabled bytes (the new bytes win) and ORs in its enables, without taking an entry. This is accepted even when the queue is full.
- R8: With cfgMerge at 0, stores to the same line always take separate entries.
- R9: When exactly one entry is queued, that entry is already on the bus, so a same-line store takes a new entry rather than merging.
- R10: Once busValid is high for a queued entry, it stays high and the bus fields stay unchanged until busReady is seen.
- R11: A flushReq pulse drives flushDone low from the next cycle until the queue is empty. During that time stReady is low for every store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEnable | input | 1 | Software buffering enable |
| cfgMerge | input | 1 | Same-line merge enable |
| mmuOn | input | 1 | Address translation active |
| flushReq | input | 1 | One-cycle flush command |
| flushDone | output | 1 | High when no flush is pending |
| stValid | input | 1 | Store request valid |
| stReady | output | 1 | Store accepted this cycle when high with stValid |
| stLineAddr | input | 28 | Line address of the store (byte address bits 31:4) |
| stData | input | 128 | Store data, lane b on bits [8b+7:8b] |
| stBe | input | 16 | Byte-lane enables of the store |
| stBufferable | input | 1 | Page attribute: store may be buffered |
| busValid | output | 1 | Bus write request valid |
| busReady | input | 1 | Bus accepts the write |
| busLineAddr | output | 28 | Line address of the bus write |
| busData | output | 128 | Bus write data |
| busBe | output | 16 | Bus write byte enables |

## Verification
If a queue pointer or the occupancy count is wrong, the bus shows the wrong line or data in the cycle after the affected push or pop. It can also show busValid with nothing queued, or stReady that disagrees with the fill level the bench has tracked, by the next store attempt. If the merge target is wrong, a merge writes into the wrong entry or fails to happen. This shows up only at drain, as bytes or enables out of place in an entry the bench can predict exactly. A stuck flush state shows at once, as flushDone or stReady staying low after the last entry leaves.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;
  localparam int AddrW     = 32;
  localparam int LineBytes = 16;
  localparam int OffW      = $clog2(LineBytes);
  localparam int LineW     = AddrW - OffW;
  localparam int DataW     = LineBytes * 8;

  // strobes from control to datapath
  typedef struct packed {
    logic push;     // write a new entry at wrIdx
    logic merge;    // fold store bytes into mergeIdx
    logic passSel;  // bus shows the live store, not the head entry
  } wbufStrb_t;
endpackage

// File: rtl/wbuf_ctrl.sv
`timescale 1ns/1ps
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int PtrW  = $clog2(DEPTH),
  localparam int CntW  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic             cfgMerge,
  input  logic             mmuOn,
  input  logic             flushReq,
  input  logic             stValid,
  input  logic             stBufferable,
  input  logic [LineW-1:0] stLineAddr,
  input  logic [LineW-1:0] youngLine,
  input  logic             busReady,
  output logic             stReady,
  output logic             busValid,
  output logic             flushDone,
  output wbufStrb_t        strb,
  output logic [PtrW-1:0]  wrIdx,
  output logic [PtrW-1:0]  mergeIdx,
  output logic [PtrW-1:0]  headIdx
);
  localparam logic [CntW-1:0] FullCnt = CntW'(DEPTH);
  localparam logic [PtrW-1:0] LastIdx = PtrW'(DEPTH - 1);

  logic [PtrW-1:0] headPtr, tailPtr;
  logic [CntW-1:0] count, countNext;
  logic            flushBusy;
  logic            bufOk, empty, mergeHit, accept, pop;

  function automatic logic [PtrW-1:0] stepPtr(input logic [PtrW-1:0] p);
    return (p == LastIdx) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    bufOk    = cfgEnable & mmuOn & stBufferable;
    empty    = (count == '0);
    mergeIdx = (tailPtr == '0) ? LastIdx : tailPtr - 1'b1;
    // the head is on the bus, so merging needs a second, younger entry
    mergeHit = cfgMerge & bufOk & (count >= CntW'(2)) & (youngLine == stLineAddr);
    if (flushBusy)  stReady = 1'b0;
    else if (bufOk) stReady = mergeHit | (count != FullCnt);
    else            stReady = empty & busReady;
    accept       = stValid & stReady;
    strb.push    = accept & bufOk & ~mergeHit;
    strb.merge   = accept & bufOk & mergeHit;
    strb.passSel = empty;
    pop          = ~empty & busReady;
    busValid     = empty ? (stValid & ~bufOk & ~flushBusy) : 1'b1;
    countNext    = count + CntW'(strb.push) - CntW'(pop);
    wrIdx        = tailPtr;
    headIdx      = headPtr;
    flushDone    = ~flushBusy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      count     <= '0;
      flushBusy <= 1'b0;
    end else begin
      if (strb.push) tailPtr <= stepPtr(tailPtr);
      if (pop)       headPtr <= stepPtr(headPtr);
      count     <= countNext;
      flushBusy <= flushReq | (flushBusy & (countNext != '0));
    end
  end

  // R6: occupancy never passes the entry count
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    count <= FullCnt);
  // R10: a queued request is not withdrawn before the bus takes it
  assert_hold_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!empty && !busReady) |=> busValid);
  // R4: an unbuffered store is taken only behind an empty queue
  assert_unbuf_order_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stValid && stReady && !bufOk) |-> empty);
  // R11: flushDone drops right after a flush request
  assert_flush_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> !flushDone);
  // R11: stores refused while flushing
  assert_flush_block_R11: assert property (@(posedge clk) disable iff (!rstN)
    !flushDone |-> !stReady);
endmodule

// File: rtl/wbuf_dp.sv
`timescale 1ns/1ps
module wbuf_dp
  import wbuf_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int PtrW  = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wbufStrb_t            strb,
  input  logic [PtrW-1:0]      wrIdx,
  input  logic [PtrW-1:0]      mergeIdx,
  input  logic [PtrW-1:0]      headIdx,
  input  logic [LineW-1:0]     stLineAddr,
  input  logic [DataW-1:0]     stData,
  input  logic [LineBytes-1:0] stBe,
  output logic [LineW-1:0]     youngLine,
  output logic [LineW-1:0]     busLineAddr,
  output logic [DataW-1:0]     busData,
  output logic [LineBytes-1:0] busBe
);
  logic [LineW-1:0]     lineQ [DEPTH];
  logic [DataW-1:0]     dataQ [DEPTH];
  logic [LineBytes-1:0] beQ   [DEPTH];
  logic [DataW-1:0]     mergedData;

  // byte-lane select between the stored entry and the new store
  for (genvar b = 0; b < LineBytes; b++) begin : g_lane
    assign mergedData[8*b +: 8] = stBe[b] ? stData[8*b +: 8]
                                          : dataQ[mergeIdx][8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < DEPTH; e++) beQ[e] <= '0;
    end else if (strb.push) begin
      lineQ[wrIdx] <= stLineAddr;
      dataQ[wrIdx] <= stData;
      beQ[wrIdx]   <= stBe;
    end else if (strb.merge) begin
      dataQ[mergeIdx] <= mergedData;
      beQ[mergeIdx]   <= beQ[mergeIdx] | stBe;
    end
  end

  always_comb begin
    youngLine   = lineQ[mergeIdx];
    busLineAddr = strb.passSel ? stLineAddr : lineQ[headIdx];
    busData     = strb.passSel ? stData     : dataQ[headIdx];
    busBe       = strb.passSel ? stBe       : beQ[headIdx];
  end

  // R7: every lane of a merged store ends up enabled in its target entry
  assert_merge_lanes_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.merge |=> ((beQ[$past(mergeIdx)] & $past(stBe)) == $past(stBe)));
endmodule

// File: rtl/store_merge_buffer.sv
`timescale 1ns/1ps
module store_merge_buffer
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgEnable,
  input  logic                 cfgMerge,
  input  logic                 mmuOn,
  input  logic                 flushReq,
  output logic                 flushDone,
  input  logic                 stValid,
  output logic                 stReady,
  input  logic [LineW-1:0]     stLineAddr,
  input  logic [DataW-1:0]     stData,
  input  logic [LineBytes-1:0] stBe,
  input  logic                 stBufferable,
  output logic                 busValid,
  input  logic                 busReady,
  output logic [LineW-1:0]     busLineAddr,
  output logic [DataW-1:0]     busData,
  output logic [LineBytes-1:0] busBe
);
  localparam int PtrW = $clog2(DEPTH);

  wbufStrb_t       strb;
  logic [PtrW-1:0] wrIdx, mergeIdx, headIdx;
  logic [LineW-1:0] youngLine;

  wbuf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMerge(cfgMerge),
    .mmuOn(mmuOn), .flushReq(flushReq), .stValid(stValid),
    .stBufferable(stBufferable), .stLineAddr(stLineAddr), .youngLine(youngLine),
    .busReady(busReady), .stReady(stReady), .busValid(busValid),
    .flushDone(flushDone), .strb(strb), .wrIdx(wrIdx), .mergeIdx(mergeIdx),
    .headIdx(headIdx)
  );

  wbuf_dp #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .mergeIdx(mergeIdx),
    .headIdx(headIdx), .stLineAddr(stLineAddr), .stData(stData), .stBe(stBe),
    .youngLine(youngLine), .busLineAddr(busLineAddr), .busData(busData),
    .busBe(busBe)
  );

  // R10: a stalled queued write keeps its fields
  assert_bus_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady && !strb.passSel) |=>
      ($stable(busLineAddr) && $stable(busBe) && $stable(busData)));
endmodule

// File: tb/store_merge_buffer_tb_top.sv
`timescale 1ns/1ps
module store_merge_buffer_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cfgEnable = 1'b1, cfgMerge = 1'b0, mmuOn = 1'b1, flushReq = 1'b0;
  logic         flushDone, stReady, busValid;
  logic         stValid = 1'b0, stBufferable = 1'b1, busReady = 1'b0;
  logic [27:0]  stLineAddr = '0, busLineAddr;
  logic [127:0] stData = '0, busData;
  logic [15:0]  stBe = '0, busBe;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  store_merge_buffer dut_i (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMerge(cfgMerge),
    .mmuOn(mmuOn), .flushReq(flushReq), .flushDone(flushDone),
    .stValid(stValid), .stReady(stReady), .stLineAddr(stLineAddr),
    .stData(stData), .stBe(stBe), .stBufferable(stBufferable),
    .busValid(busValid), .busReady(busReady), .busLineAddr(busLineAddr),
    .busData(busData), .busBe(busBe)
  );

  // qualification table: {cfgEnable, mmuOn, stBufferable, expectQueued}
  localparam logic [3:0] QualVec [8] = '{
    4'b0000, 4'b0010, 4'b0100, 4'b0110, 4'b1000, 4'b1010, 4'b1100, 4'b1111
  };

  function automatic logic [127:0] pat(input logic [7:0] seed);
    logic [127:0] d;
    for (int b = 0; b < 16; b++) d[8*b +: 8] = seed + 8'(b * 17);
    return d;
  endfunction

  function automatic logic [127:0] mix(input logic [127:0] oldD, newD, input logic [15:0] be);
    logic [127:0] d;
    for (int b = 0; b < 16; b++) d[8*b +: 8] = be[b] ? newD[8*b +: 8] : oldD[8*b +: 8];
    return d;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doStore(input logic [27:0] line, input logic [15:0] be, input logic [127:0] d);
    @(negedge clk);
    stValid = 1'b1; stBufferable = 1'b1; stLineAddr = line; stBe = be; stData = d;
    #1;
    while (!stReady) begin @(negedge clk); #1; end
    @(posedge clk); #1 stValid = 1'b0;
  endtask

  task automatic drainOne(input logic [27:0] line, input logic [15:0] be,
                          input logic [127:0] d, input string tag);
    @(negedge clk);
    busReady = 1'b1;
    #1;
    chk(busValid === 1'b1, {tag, " valid"}, 128'(busValid), 128'd1);
    chk(busLineAddr === line, {tag, " line"}, 128'(busLineAddr), 128'(line));
    chk(busBe === be, {tag, " be"}, 128'(busBe), 128'(be));
    chk(busData === d, {tag, " data"}, busData, d);
    @(posedge clk); #1 busReady = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    chk(busValid === 1'b0, "R1 busValid", 128'(busValid), 128'd0);
    chk(flushDone === 1'b1, "R1 flushDone", 128'(flushDone), 128'd1);
    stValid = 1'b1; stLineAddr = 28'h1; stBe = 16'h1; #1;
    chk(stReady === 1'b1, "R1 stReady", 128'(stReady), 128'd1);
    stValid = 1'b0;

    // R2 / R3: qualification table walk
    foreach (QualVec[i]) begin
      logic [27:0] ln;
      ln = 28'h100 + 28'(i);
      @(negedge clk);
      {cfgEnable, mmuOn, stBufferable} = QualVec[i][3:1];
      stValid = 1'b1; stLineAddr = ln; stBe = 16'h00F0; stData = pat(8'(i)); busReady = 1'b0;
      #1;
      if (QualVec[i][0]) begin
        chk(stReady === 1'b1 && busValid === 1'b0, "R2 queued accept", {stReady, busValid}, 2'b10);
      end else begin
        chk(busValid === 1'b1 && busLineAddr === ln && stReady === 1'b0, "R3 passthrough",
            128'(busLineAddr), 128'(ln));
        busReady = 1'b1; #1;
        chk(stReady === 1'b1 && busData === pat(8'(i)), "R3 ready follows bus", busData, pat(8'(i)));
      end
      @(posedge clk); #1 stValid = 1'b0; busReady = 1'b0;
      #1;
      if (QualVec[i][0]) drainOne(ln, 16'h00F0, pat(8'(i)), "R2 drained entry");
      else chk(busValid === 1'b0, "R3 nothing queued", 128'(busValid), 128'd0);
    end
    cfgEnable = 1'b1; mmuOn = 1'b1; stBufferable = 1'b1;

    // R5: FIFO order
    doStore(28'hA1, 16'h000F, pat(8'h10));
    doStore(28'hA2, 16'hFFFF, pat(8'h20));
    doStore(28'hA3, 16'h8001, pat(8'h30));
    drainOne(28'hA1, 16'h000F, pat(8'h10), "R5 first");
    drainOne(28'hA2, 16'hFFFF, pat(8'h20), "R5 second");
    drainOne(28'hA3, 16'h8001, pat(8'h30), "R5 third");

    // R6 / R7: fill, merge into a full queue, refuse a new line
    cfgMerge = 1'b1;
    for (int k = 0; k < 8; k++) doStore(28'h200 + 28'(k), 16'h0003, pat(8'(k)));
    @(negedge clk);
    stValid = 1'b1; stLineAddr = 28'h207; stBe = 16'hC000; stData = pat(8'h77); #1;
    chk(stReady === 1'b1, "R7 merge when full", 128'(stReady), 128'd1);
    @(posedge clk); #1 stValid = 1'b0;
    @(negedge clk);
    stValid = 1'b1; stLineAddr = 28'h300; stBe = 16'h0001; #1;
    chk(stReady === 1'b0, "R6 full refuses", 128'(stReady), 128'd0);
    stValid = 1'b0;
    for (int k = 0; k < 7; k++) drainOne(28'h200 + 28'(k), 16'h0003, pat(8'(k)), "R6 drain");
    drainOne(28'h207, 16'hC003, mix(pat(8'h07), pat(8'h77), 16'hC000), "R7 merged entry");

    // R9: single entry is in flight, so no merge; the third store merges
    doStore(28'h400, 16'h000F, pat(8'h41));
    doStore(28'h400, 16'h00F0, pat(8'h42));
    doStore(28'h400, 16'h0F00, pat(8'h43));
    drainOne(28'h400, 16'h000F, pat(8'h41), "R9 head untouched");
    drainOne(28'h400, 16'h0FF0, mix(pat(8'h42), pat(8'h43), 16'h0F00), "R9 second merged");

    // R8: merge disabled keeps entries apart
    cfgMerge = 1'b0;
    doStore(28'h500, 16'h0001, pat(8'h51));
    doStore(28'h500, 16'h0002, pat(8'h52));
    doStore(28'h500, 16'h0004, pat(8'h53));
    drainOne(28'h500, 16'h0001, pat(8'h51), "R8 first");
    drainOne(28'h500, 16'h0002, pat(8'h52), "R8 second");
    drainOne(28'h500, 16'h0004, pat(8'h53), "R8 third");

    // R10: stalled request holds
    doStore(28'h600, 16'h00FF, pat(8'h61));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(busValid === 1'b1 && busLineAddr === 28'h600 && busData === pat(8'h61),
          "R10 held", busData, pat(8'h61));
    end
    drainOne(28'h600, 16'h00FF, pat(8'h61), "R10 drain");

    // R4: unbuffered store waits behind a queued entry
    doStore(28'h700, 16'h0001, pat(8'h71));
    @(negedge clk);
    stValid = 1'b1; stBufferable = 1'b0; stLineAddr = 28'h7FF; stBe = 16'hFFFF;
    stData = pat(8'h7F); busReady = 1'b1; #1;
    chk(stReady === 1'b0, "R4 held off", 128'(stReady), 128'd0);
    chk(busLineAddr === 28'h700, "R4 head shown", 128'(busLineAddr), 128'h700);
    @(negedge clk); #1;
    chk(stReady === 1'b1 && busLineAddr === 28'h7FF, "R3 after drain",
        128'(busLineAddr), 128'h7FF);
    @(posedge clk); #1 stValid = 1'b0; busReady = 1'b0; stBufferable = 1'b1;
    #1 chk(busValid === 1'b0, "R4 idle after", 128'(busValid), 128'd0);

    // R11: flush
    doStore(28'h800, 16'h0001, pat(8'h81));
    doStore(28'h801, 16'h0002, pat(8'h82));
    @(negedge clk); flushReq = 1'b1;
    @(posedge clk); #1 flushReq = 1'b0;
    @(negedge clk);
    stValid = 1'b1; stLineAddr = 28'h900; stBe = 16'h0001; #1;
    chk(flushDone === 1'b0, "R11 flushDone low", 128'(flushDone), 128'd0);
    chk(stReady === 1'b0, "R11 store refused", 128'(stReady), 128'd0);
    stValid = 1'b0;
    drainOne(28'h800, 16'h0001, pat(8'h81), "R11 drain");
    #1 chk(flushDone === 1'b0, "R11 still low", 128'(flushDone), 128'd0);
    drainOne(28'h801, 16'h0002, pat(8'h82), "R11 drain");
    @(negedge clk); #1;
    chk(flushDone === 1'b1, "R11 flushDone back", 128'(flushDone), 128'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule